// File: doc/BRIEF.md
# Pulse-Verify Byte Programming Sequencer

This block is the control engine of an external programmer for a byte-wide, electrically programmable memory. When `start` is pulsed, it walks the address space from address 0. It fetches each target byte from a local source buffer and drives the memory's strobes, its address and data, and a flag that asks for the raised programming supply. Every byte gets one program pulse of fixed width followed by a verify read. A byte that reads back wrong is pulsed again, up to a bounded number of attempts. When the attempts run out, the run stops with a failure that names the address.

Once every byte has verified, the sequencer drops the programming supply back to normal. It then reads the whole array again and compares each byte with the source image, because a byte can verify at raised supply and still read wrong at normal supply. All pulse, setup, hold and wait intervals are counted in microseconds. The microsecond tick comes from a clock divider set by a parameter, so a test environment can compress time. At the end, `done` is high for one cycle, and `pass`/`fail` and `fail_addr` stay latched until the next start.

Top module: `pgm_seq`

## Requirements
- R1: A program pulse (`mem_pgm_n` low) occurs only while `mem_vpp_hi`=1, `mem_ce_n`=0, `mem_oe_n`=1 and `mem_data_oe`=1. After `start`, the first pulse of a run is applied to address 0.
- R2: Each program pulse keeps `mem_pgm_n` low for exactly PULSE_US microseconds, which is PULSE_US*CLK_PER_US clock cycles (100 us by default).
- R3: Address, write data, supply flag and chip enable are unchanged for at least SETUP_US microseconds before a pulse falls. Address and write data stay driven for at least HOLD_US microseconds after it rises.
- R4: `mem_oe_n` has been high for at least OE_SETUP_US microseconds whenever it falls for a read.
- R5: After each pulse, the byte is read with `mem_oe_n`=0 and compared with `src_data`. A match advances to the next address. The MAX_TRY-th consecutive mismatch (25 by default) ends the run with `fail`=1 and `fail_addr` set to that address, and no later address is pulsed.
- R6: The attempt count starts again from zero at every new address, so two separate bytes that each need up to MAX_TRY pulses both program.
- R7: After the last address verifies, `mem_vpp_hi` drops and each byte from address 0 upward is read and compared. The first mismatch ends the run with `fail`=1 and `fail_addr` set to its address. If no byte mismatches, the run ends with `pass`=1.
- R8: `busy` is high from the cycle after `start` until the run ends. `done` is then high for exactly one cycle with `busy` low and exactly one of `pass`/`fail` set. The flags hold until the next start.
- R9: After reset, `mem_ce_n`, `mem_oe_n` and `mem_pgm_n` are 1, and `mem_vpp_hi`, `mem_data_oe`, `busy`, `done`, `pass` and `fail` are 0.
- R10: `src_addr` always equals `mem_addr`, and `mem_wdata` carries `src_data` while the sequencer drives the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a programming run when idle |
| src_addr | output | ADDR_W | Read address into the source buffer |
| src_data | input | DATA_W | Source byte at `src_addr` |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Data driven to the memory |
| mem_data_oe | output | 1 | 1 while the sequencer drives the data bus |
| mem_rdata | input | DATA_W | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| mem_vpp_hi | output | 1 | Request for the raised programming supply |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Last run succeeded |
| fail | output | 1 | Last run failed |
| fail_addr | output | ADDR_W | Address that caused the failure |

## Verification
The hardest case to reach from the ports is a byte that verifies correctly at raised supply but reads wrong once the supply is normal. It can only show up in the final comparison pass. The bench memory model produces it with a marginal-cell address whose bit 0 is flipped only when `mem_vpp_hi` is low. The attempt limit is just as indirect. The model gives chosen addresses a count of pulses they need before they take data, and runs are set up so that a byte lands exactly on the limit, one past it, and on the last address.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_VERIFY,
    ST_LOWER,
    ST_COMPARE,
    ST_DONE
  } seq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // The next miss is final when this many misses are already counted.
  function automatic logic is_final_try(input int unsigned misses, input int unsigned limit);
    return (misses + 1) >= limit;
  endfunction

  function automatic int unsigned us_to_cycles(input int unsigned us, input int unsigned clk_per_us);
    return us * clk_per_us;
  endfunction

endpackage

// File: rtl/pgm_tick_div.sv
module pgm_tick_div #(
  parameter int unsigned CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (CLK_PER_US < 2) ? 1 : $clog2(CLK_PER_US);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(CLK_PER_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || tick)  cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pgm_us_timer.sv
module pgm_us_timer #(
  parameter int unsigned MAX_US = 100,
  localparam int unsigned UW = $clog2(MAX_US + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [UW-1:0] len,
  input  logic          tick,
  output logic          expire
);
  logic [UW-1:0] left_q;

  assign expire = tick && (left_q == UW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         left_q <= '0;
    else if (load)                      left_q <= len;
    else if (tick && (left_q != '0))    left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/pgm_try_ctr.sv
module pgm_try_ctr
  import pgm_seq_pkg::*;
#(
  parameter int unsigned MAX_TRY = 25,
  localparam int unsigned TW = $clog2(MAX_TRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [TW-1:0] count,
  output logic          final_try
);
  logic [TW-1:0] cnt_q;

  assign count     = cnt_q;
  assign final_try = is_final_try(32'(cnt_q), MAX_TRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
  import pgm_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CLK_PER_US  = 50,
  parameter int unsigned PULSE_US    = 100,
  parameter int unsigned SETUP_US    = 2,
  parameter int unsigned HOLD_US     = 2,
  parameter int unsigned OE_SETUP_US = 2,
  parameter int unsigned VERIFY_US   = 1,
  parameter int unsigned MAX_TRY     = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_data_oe,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_pgm_n,
  output logic              mem_vpp_hi,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  // Intervals that also cover the output-enable high time before a read
  localparam int unsigned HOLD_LEN   = max_u(HOLD_US, OE_SETUP_US);
  localparam int unsigned LOWER_LEN  = max_u(SETUP_US, OE_SETUP_US);
  localparam int unsigned LONGEST_US = max_u(max_u(PULSE_US, SETUP_US),
                                             max_u(max_u(HOLD_LEN, LOWER_LEN), VERIFY_US));
  localparam int unsigned TMR_W      = $clog2(LONGEST_US + 1);
  localparam int unsigned TRY_W      = $clog2(MAX_TRY + 1);

  seq_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              pass_q, fail_q;
  logic [ADDR_W-1:0] fail_addr_q;

  logic              tick, tmr_expire, tmr_load;
  logic [TMR_W-1:0]  tmr_len;
  logic              try_clr, try_inc, try_final;
  logic [TRY_W-1:0]  try_cnt;
  logic              addr_clr, addr_inc, res_clr, set_pass, set_fail;

  // Named events for the checker
  logic byte_match, verify_miss, cmp_phase, last_addr;

  assign byte_match  = (mem_rdata == src_data);
  assign last_addr   = &addr_q;
  assign verify_miss = (state_q == ST_VERIFY) && tmr_expire && !byte_match;
  assign cmp_phase   = (state_q == ST_COMPARE);

  pgm_tick_div #(.CLK_PER_US(CLK_PER_US)) div_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tmr_load),
    .tick (tick)
  );

  pgm_us_timer #(.MAX_US(LONGEST_US)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .len   (tmr_len),
    .tick  (tick),
    .expire(tmr_expire)
  );

  pgm_try_ctr #(.MAX_TRY(MAX_TRY)) try_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (try_clr),
    .inc      (try_inc),
    .count    (try_cnt),
    .final_try(try_final)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    res_clr  = 1'b0;
    set_pass = 1'b0;
    set_fail = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(SETUP_US);
          try_clr  = 1'b1;
          addr_clr = 1'b1;
          res_clr  = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tmr_expire) begin
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(PULSE_US);
        end
      end
      ST_PULSE: begin
        if (tmr_expire) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(HOLD_LEN);
        end
      end
      ST_HOLD: begin
        if (tmr_expire) begin
          state_d  = ST_VERIFY;
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(VERIFY_US);
        end
      end
      ST_VERIFY: begin
        if (tmr_expire) begin
          if (byte_match) begin
            try_clr  = 1'b1;
            tmr_load = 1'b1;
            if (last_addr) begin
              state_d  = ST_LOWER;
              tmr_len  = TMR_W'(LOWER_LEN);
              addr_clr = 1'b1;
            end else begin
              state_d  = ST_SETUP;
              tmr_len  = TMR_W'(SETUP_US);
              addr_inc = 1'b1;
            end
          end else if (try_final) begin
            state_d  = ST_DONE;
            set_fail = 1'b1;
          end else begin
            state_d  = ST_SETUP;
            tmr_load = 1'b1;
            tmr_len  = TMR_W'(SETUP_US);
            try_inc  = 1'b1;
          end
        end
      end
      ST_LOWER: begin
        if (tmr_expire) begin
          state_d  = ST_COMPARE;
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(VERIFY_US);
        end
      end
      ST_COMPARE: begin
        if (tmr_expire) begin
          if (!byte_match) begin
            state_d  = ST_DONE;
            set_fail = 1'b1;
          end else if (last_addr) begin
            state_d  = ST_DONE;
            set_pass = 1'b1;
          end else begin
            addr_inc = 1'b1;
            tmr_load = 1'b1;
            tmr_len  = TMR_W'(VERIFY_US);
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (addr_clr)      addr_q <= '0;
      else if (addr_inc) addr_q <= addr_q + 1'b1;
      if (res_clr) begin
        pass_q      <= 1'b0;
        fail_q      <= 1'b0;
        fail_addr_q <= '0;
      end
      if (set_pass) pass_q <= 1'b1;
      if (set_fail) begin
        fail_q      <= 1'b1;
        fail_addr_q <= addr_q;
      end
    end
  end

  // Pin decode from the state register
  assign src_addr    = addr_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = src_data;
  assign mem_vpp_hi  = (state_q == ST_SETUP) || (state_q == ST_PULSE) ||
                       (state_q == ST_HOLD)  || (state_q == ST_VERIFY);
  assign mem_data_oe = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign mem_ce_n    = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign mem_oe_n    = !((state_q == ST_VERIFY) || (state_q == ST_COMPARE));
  assign mem_pgm_n   = (state_q != ST_PULSE);

  assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done      = (state_q == ST_DONE);
  assign pass      = pass_q;
  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;
endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk
  import pgm_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CLK_PER_US  = 50,
  parameter int unsigned PULSE_US    = 100,
  parameter int unsigned SETUP_US    = 2,
  parameter int unsigned HOLD_US     = 2,
  parameter int unsigned OE_SETUP_US = 2,
  parameter int unsigned MAX_TRY     = 25,
  parameter int unsigned TRY_W       = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_data_oe,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_pgm_n,
  input logic              mem_vpp_hi,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic [TRY_W-1:0]  try_cnt,
  input logic              verify_miss,
  input logic              try_final,
  input logic              cmp_phase
);
  localparam int unsigned PULSE_CYC = us_to_cycles(PULSE_US, CLK_PER_US);
  localparam int unsigned SETUP_CYC = us_to_cycles(SETUP_US, CLK_PER_US);
  localparam int unsigned HOLD_CYC  = us_to_cycles(HOLD_US, CLK_PER_US);
  localparam int unsigned OE_CYC    = us_to_cycles(OE_SETUP_US, CLK_PER_US);

  localparam int unsigned SW = ADDR_W + DATA_W + 2;

  logic [31:0]   low_cnt, stable_cnt, since_rise, oe_hi_cnt;
  logic [SW-1:0] sig_prev;
  logic          pgm_prev;
  logic [SW-1:0] sig_now;

  assign sig_now = {mem_addr, mem_wdata, mem_vpp_hi, mem_ce_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      stable_cnt <= '0;
      since_rise <= '0;
      oe_hi_cnt  <= '0;
      sig_prev   <= '0;
      pgm_prev   <= 1'b1;
    end else begin
      sig_prev <= sig_now;
      pgm_prev <= mem_pgm_n;
      low_cnt  <= mem_pgm_n ? '0 : low_cnt + 1;
      if (sig_now != sig_prev)       stable_cnt <= 32'd1;
      else if (stable_cnt != '1)     stable_cnt <= stable_cnt + 1;
      if (mem_pgm_n && !pgm_prev)    since_rise <= 32'd1;
      else if (since_rise != '1)     since_rise <= since_rise + 1;
      if (!mem_oe_n)                 oe_hi_cnt  <= '0;
      else if (oe_hi_cnt != '1)      oe_hi_cnt  <= oe_hi_cnt + 1;
    end
  end

  AST_PGM_CONDITIONS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> (mem_vpp_hi && !mem_ce_n && mem_oe_n && mem_data_oe)); // R1

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pgm_n) |-> (low_cnt == PULSE_CYC)); // R2

  AST_SETUP_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_pgm_n) |-> (stable_cnt >= SETUP_CYC)); // R3

  AST_HOLD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_data_oe) |-> (since_rise >= HOLD_CYC)); // R3

  AST_OE_HIGH_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (oe_hi_cnt >= OE_CYC)); // R4

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(try_cnt) < MAX_TRY); // R5

  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (verify_miss && try_final) |=> (done && fail)); // R5

  AST_COMPARE_NORMAL_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_phase |-> (!mem_vpp_hi && !mem_ce_n)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pass ^ fail) && !busy)); // R8
endmodule

bind pgm_seq pgm_seq_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .CLK_PER_US (CLK_PER_US),
  .PULSE_US   (PULSE_US),
  .SETUP_US   (SETUP_US),
  .HOLD_US    (HOLD_US),
  .OE_SETUP_US(OE_SETUP_US),
  .MAX_TRY    (MAX_TRY),
  .TRY_W      (TRY_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_data_oe(mem_data_oe),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_pgm_n  (mem_pgm_n),
  .mem_vpp_hi (mem_vpp_hi),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .fail       (fail),
  .try_cnt    (try_cnt),
  .verify_miss(verify_miss),
  .try_final  (try_final),
  .cmp_phase  (cmp_phase)
);

// File: tb/pgm_seq_tb.sv
module pgm_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int KPU = 4;          // clocks per microsecond in the bench
  localparam int LIMIT = 25;
  localparam int RUN_WDOG = 60000;

  typedef struct packed {
    logic [7:0]  seed;
    logic [7:0]  weak_a;    // 8'hFF: none
    logic [7:0]  weak_n;    // pulses that address needs
    logic [7:0]  weak_b;
    logic [7:0]  weak_m;
    logic [7:0]  margin_a;  // address that reads wrong at normal supply
    logic        exp_pass;
    logic [7:0]  exp_fail_addr;
    logic [15:0] exp_pulses;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8'h11, 8'hFF, 8'd1,  8'hFF, 8'd1,  8'hFF, 1'b1, 8'd0,  16'd16}, // clean image
    '{8'h2A, 8'd5,  8'd3,  8'hFF, 8'd1,  8'hFF, 1'b1, 8'd0,  16'd18}, // one slow byte
    '{8'h35, 8'd9,  8'd25, 8'hFF, 8'd1,  8'hFF, 1'b1, 8'd0,  16'd40}, // exactly at limit
    '{8'h40, 8'd3,  8'd26, 8'hFF, 8'd1,  8'hFF, 1'b0, 8'd3,  16'd28}, // one past limit
    '{8'h07, 8'd2,  8'd20, 8'd7,  8'd20, 8'hFF, 1'b1, 8'd0,  16'd54}, // two slow bytes
    '{8'h5C, 8'hFF, 8'd1,  8'hFF, 8'd1,  8'd12, 1'b0, 8'd12, 16'd16}, // marginal cell
    '{8'h63, 8'd15, 8'd26, 8'hFF, 8'd1,  8'hFF, 1'b0, 8'd15, 16'd40}  // last address stuck
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] src_addr, mem_addr, fail_addr;
  logic [DW-1:0] src_data, mem_wdata, mem_rdata;
  logic mem_data_oe, mem_ce_n, mem_oe_n, mem_pgm_n, mem_vpp_hi;
  logic busy, done, pass, fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgm_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PER_US(KPU), .PULSE_US(100), .SETUP_US(2),
    .HOLD_US(2), .OE_SETUP_US(2), .VERIFY_US(1), .MAX_TRY(LIMIT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_addr(src_addr), .src_data(src_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_data_oe(mem_data_oe),
    .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_pgm_n(mem_pgm_n), .mem_vpp_hi(mem_vpp_hi),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Source image: top bit clear, so no byte equals the erased value
  function automatic logic [7:0] image_byte(input int a, input logic [7:0] seed);
    return 8'(((a * 13) + int'(seed)) & 8'h7F);
  endfunction

  // ---------------- memory model ----------------
  logic [7:0] cur_seed = 8'h00;
  int         margin_addr = -1;
  logic [7:0] mem [DEPTH];
  int         need [DEPTH];
  int         pulses = 0;
  int         first_pulse_addr = -1;
  bit         first_pulse_vpp = 1'b0;
  bit         src_mismatch = 1'b0;

  always_comb src_data = image_byte(int'(src_addr), cur_seed);

  always_comb begin
    mem_rdata = 8'h00;
    if (!mem_ce_n && !mem_oe_n) begin
      mem_rdata = mem[mem_addr];
      if (!mem_vpp_hi && int'(mem_addr) == margin_addr) mem_rdata = mem_rdata ^ 8'h01;
    end
  end

  always @(posedge mem_pgm_n) begin
    if (rst_n && !mem_ce_n && mem_oe_n && mem_vpp_hi) begin
      if (pulses == 0) begin
        first_pulse_addr = int'(mem_addr);
        first_pulse_vpp  = mem_vpp_hi;
      end
      pulses++;
      need[mem_addr] = need[mem_addr] - 1;
      if (need[mem_addr] <= 0) mem[mem_addr] = mem[mem_addr] & mem_wdata;
    end
  end

  // ---------------- timing monitor ----------------
  int low_cnt = 0, st_cnt = 0, since_rise = 0, oe_hi = 0;
  int min_width = 1 << 30, max_width = 0, min_setup = 1 << 30;
  int min_hold = 1 << 30, min_oe = 1 << 30;
  logic prev_pgm = 1'b1, prev_oe = 1'b1, prev_doe = 1'b0;
  logic [AW+DW+1:0] prev_sig = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_addr !== src_addr) src_mismatch = 1'b1;
      if (mem_data_oe && mem_wdata !== src_data) src_mismatch = 1'b1;
      if (!mem_pgm_n) low_cnt++;
      if (mem_pgm_n && !prev_pgm) begin
        if (low_cnt < min_width) min_width = low_cnt;
        if (low_cnt > max_width) max_width = low_cnt;
        low_cnt = 0;
      end
      if (!mem_pgm_n && prev_pgm && st_cnt < min_setup) min_setup = st_cnt;
      if ({mem_addr, mem_wdata, mem_vpp_hi, mem_ce_n} != prev_sig) st_cnt = 1;
      else st_cnt++;
      if (prev_doe && !mem_data_oe && since_rise < min_hold) min_hold = since_rise;
      since_rise = (mem_pgm_n && !prev_pgm) ? 1 : since_rise + 1;
      if (!mem_oe_n && prev_oe && oe_hi < min_oe) min_oe = oe_hi;
      oe_hi = mem_oe_n ? oe_hi + 1 : 0;
      prev_sig = {mem_addr, mem_wdata, mem_vpp_hi, mem_ce_n};
      prev_pgm = mem_pgm_n;
      prev_oe  = mem_oe_n;
      prev_doe = mem_data_oe;
    end
  end

  // ---------------- one programming run ----------------
  task automatic run_vec(input int idx, input vec_t v);
    int  waited;
    bit  early;
    logic [7:0] want;
    int  bad;
    cur_seed    = v.seed;
    margin_addr = (v.margin_a == 8'hFF) ? -1 : int'(v.margin_a);
    for (int a = 0; a < DEPTH; a++) begin
      mem[a]  = 8'hFF;
      need[a] = 1;
      if (v.weak_a != 8'hFF && a == int'(v.weak_a)) need[a] = int'(v.weak_n);
      if (v.weak_b != 8'hFF && a == int'(v.weak_b)) need[a] = int'(v.weak_m);
    end
    pulses = 0;
    first_pulse_addr = -1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R8", $sformatf("vec%0d busy after start", idx),
          longint'(busy), 1);
    waited = 0;
    while (done !== 1'b1 && waited < RUN_WDOG) begin
      @(negedge clk);
      waited++;
    end
    check(waited < RUN_WDOG, "R8", $sformatf("vec%0d watchdog", idx), waited, RUN_WDOG);
    check(busy === 1'b0 && (pass ^ fail) === 1'b1, "R8",
          $sformatf("vec%0d verdict one-hot at done", idx), longint'({busy, pass, fail}), 2);
    // R5 R7: verdict and failing address
    check(pass === v.exp_pass && fail === !v.exp_pass, v.exp_pass ? "R5" : "R7",
          $sformatf("vec%0d pass flag", idx), longint'(pass), longint'(v.exp_pass));
    if (!v.exp_pass)
      check(fail_addr === AW'(v.exp_fail_addr), (margin_addr >= 0) ? "R7" : "R5",
            $sformatf("vec%0d fail_addr", idx), longint'(fail_addr), longint'(v.exp_fail_addr));
    check(pulses == int'(v.exp_pulses), (v.weak_b != 8'hFF) ? "R6" : "R5",
          $sformatf("vec%0d pulse count", idx), pulses, longint'(v.exp_pulses));
    check(first_pulse_addr == 0 && first_pulse_vpp, "R1",
          $sformatf("vec%0d first pulse address", idx), first_pulse_addr, 0);
    // Array content: bytes after an early stop stay erased (R5)
    early = !v.exp_pass && (margin_addr < 0);
    bad = -1;
    for (int a = 0; a < DEPTH; a++) begin
      if (need[a] > 0 || (early && a > int'(v.exp_fail_addr))) want = 8'hFF;
      else want = image_byte(a, v.seed);
      if (mem[a] !== want && bad < 0) bad = a;
    end
    check(bad < 0, "R5", $sformatf("vec%0d array image, first bad address", idx), bad, -1);
    @(negedge clk);
    check(done === 1'b0, "R8", $sformatf("vec%0d done width", idx), longint'(done), 0);
    check(pass === v.exp_pass, "R8", $sformatf("vec%0d flag holds", idx),
          longint'(pass), longint'(v.exp_pass));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check({mem_ce_n, mem_oe_n, mem_pgm_n, mem_vpp_hi, mem_data_oe, busy, done, pass, fail}
          === 9'b111_000000, "R9", "pins and flags in reset",
          longint'({mem_ce_n, mem_oe_n, mem_pgm_n, mem_vpp_hi, mem_data_oe, busy, done, pass, fail}),
          longint'(9'b111_000000));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({mem_ce_n, mem_oe_n, mem_pgm_n, mem_vpp_hi, busy} === 5'b11100, "R9",
          "idle after reset release",
          longint'({mem_ce_n, mem_oe_n, mem_pgm_n, mem_vpp_hi, busy}), longint'(5'b11100));

    for (int i = 0; i < NVEC; i++) run_vec(i, VECS[i]);

    // Timing rules gathered over all runs
    check(min_width == 100 * KPU && max_width == 100 * KPU, "R2", "pulse width cycles",
          min_width, 100 * KPU);
    check(min_setup >= 2 * KPU, "R3", "setup cycles before pulse", min_setup, 2 * KPU);
    check(min_hold >= 2 * KPU, "R3", "hold cycles after pulse", min_hold, 2 * KPU);
    check(min_oe >= 2 * KPU, "R4", "output enable high before read", min_oe, 2 * KPU);
    check(!src_mismatch, "R10", "source address and write data follow", src_mismatch, 0);

    // Back-to-back run after a failure clears the verdict
    run_vec(NVEC, VECS[0]);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule